// File: doc/BRIEF.md
# Composite Sync Pulse Qualification Filter

This block cleans a sliced composite-sync logic level before any timing is extracted from it. The level is brought into the system clock domain through a short synchronizer chain. When filtering is selected, a new level is accepted only after it has been seen on a programmable number of consecutive samples. Short noise spikes and burst-like artifacts near the slicing point therefore never reach the output. Every edge that survives leaves the block shifted by exactly that qualification window, and the width of a surviving pulse is kept. The window is given in clock ticks, so when the sampling clock comes from the line-rate timebase the rejection window scales with line frequency.

A select pin chooses between the qualified path and a bypass. In bypass the synchronized level goes straight to the output register, so there is no filtering and no added window delay. Both paths end in the same output register, which keeps the output free of combinational glitches. The sync level is active low, so reset and idle hold the output high. The data here is a single level sampled every clock. It has no valid/ready handshake and no back-pressure: one sample enters and one leaves on every cycle.

Top module: `csync_qual_filter`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, `sync_out` is 1, which is the inactive sync level.
- R2: With `filt_en` = 0 (bypass), a change on `sync_in` that is set up before clock edge k shows on `sync_out` after edge k+2. Pulses of every width, down to one sample, pass with their width unchanged.
- R3: With `filt_en` = 1, a level that `sync_in` holds for at least L consecutive samples reaches `sync_out` with its width unchanged. L is `win_len`, except that L is 1 when `win_len` is 0.
- R4: With `filt_en` = 1, a surviving edge shows on `sync_out` after edge k+2+L. That is exactly L cycles later than the same edge in bypass.
- R5: With `filt_en` = 1, a low pulse in a high level that lasts fewer than L samples leaves `sync_out` unchanged. A high gap in a low level that lasts fewer than L samples is also removed.
- R6: A `win_len` of 0 and a `win_len` of 1 both give a one-sample window: every pulse passes, delayed by one cycle compared with bypass.
- R7: Two runs shorter than L that are split by a single sample of the old level do not add up. The qualification count starts again from zero, and the output stays unchanged.
- R8: The encoding of `filt_en` is 1 for the qualified path and 0 for the bypass path. Both paths share one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (line-rate timebase) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Sliced composite-sync level, active low |
| filt_en | input | 1 | 1 = qualify with the window, 0 = bypass |
| win_len | input | LEN_W | Qualification window in samples (0 is treated as 1) |
| sync_out | output | 1 | Registered, qualified sync level |

## Verification
The bench sweeps pulse widths around each window size, for low pulses and for high gaps, in both modes. Widths of exactly L-1 and exactly L are where an off-by-one in the count comparison shows. Such a design either lets a one-sample-too-short spike through or drops a legal pulse, and it shifts every surviving edge by one cycle. The zero-length window catches a design that would never commit, or that would commit forever. The split-run case catches a counter that is not cleared when the input returns to the committed level, which would let a chain of short spikes build up into a false sync pulse.

// File: rtl/csq_pkg.sv
package csq_pkg;

  // Inactive level of an active-low sync stream
  localparam logic SYNC_IDLE = 1'b1;

  // Output path select encoding (matches the filt_en pin)
  typedef enum logic {
    PATH_BYPASS = 1'b0,
    PATH_FILTER = 1'b1
  } path_sel_e;

endpackage

// File: rtl/csq_sync_chain.sv
module csq_sync_chain
  import csq_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= SYNC_IDLE;
          else        stg_q[i] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= SYNC_IDLE;
          else        stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign d_out = stg_q[STAGES-1];

endmodule

// File: rtl/csq_qualifier.sv
module csq_qualifier
  import csq_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_lvl,
  input  logic [LEN_W-1:0] win_len,
  output logic             qual_lvl,
  output logic [LEN_W-1:0] run_cnt
);

  localparam int EXT_W = LEN_W + 1;

  logic [EXT_W-1:0] cnt_next;
  logic [EXT_W-1:0] win_eff;
  logic             differs;
  logic             commit;

  // A zero window behaves like a one-sample window
  assign win_eff  = (win_len == '0) ? EXT_W'(1) : {1'b0, win_len};
  assign cnt_next = {1'b0, run_cnt} + EXT_W'(1);
  assign differs  = (smp_lvl != qual_lvl);
  assign commit   = differs && (cnt_next >= win_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_lvl <= SYNC_IDLE;
      run_cnt  <= '0;
    end else if (!differs) begin
      run_cnt  <= '0;
    end else if (commit) begin
      qual_lvl <= smp_lvl;
      run_cnt  <= '0;
    end else begin
      run_cnt  <= cnt_next[LEN_W-1:0];
    end
  end

endmodule

// File: rtl/csq_out_stage.sv
module csq_out_stage
  import csq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic filt_en,
  input  logic raw_lvl,
  input  logic qual_lvl,
  output logic out_lvl
);

  path_sel_e sel;
  logic      pick;

  assign sel = path_sel_e'(filt_en);

  always_comb begin
    case (sel)
      PATH_FILTER: pick = qual_lvl;
      default:     pick = raw_lvl;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_lvl <= SYNC_IDLE;
    else        out_lvl <= pick;
  end

endmodule

// File: rtl/csync_qual_filter.sv
module csync_qual_filter
  import csq_pkg::*;
#(
  parameter int LEN_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             filt_en,
  input  logic [LEN_W-1:0] win_len,
  output logic             sync_out
);

  logic             smp_lvl;
  logic             qual_lvl;
  logic [LEN_W-1:0] run_cnt;

  csq_sync_chain #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (sync_in),
    .d_out (smp_lvl)
  );

  csq_qualifier #(
    .LEN_W (LEN_W)
  ) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_lvl  (smp_lvl),
    .win_len  (win_len),
    .qual_lvl (qual_lvl),
    .run_cnt  (run_cnt)
  );

  csq_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .filt_en  (filt_en),
    .raw_lvl  (smp_lvl),
    .qual_lvl (qual_lvl),
    .out_lvl  (sync_out)
  );

endmodule

// File: rtl/csync_qual_filter_chk.sv
module csync_qual_filter_chk #(
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             filt_en,
  input logic [LEN_W-1:0] win_len,
  input logic             sync_out,
  input logic             smp_lvl,
  input logic             qual_lvl,
  input logic [LEN_W-1:0] run_cnt
);

  // Cycles since reset release, saturating, so that $past stays in range
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> sync_out); // R1

  AST_BYPASS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && !$past(filt_en)) |-> sync_out == $past(smp_lvl)); // R2

  AST_FILTER_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && $past(filt_en)) |-> sync_out == $past(qual_lvl)); // R8

  AST_COMMIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && qual_lvl != $past(qual_lvl)) |-> qual_lvl == $past(smp_lvl)); // R3

  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && $past(smp_lvl) == $past(qual_lvl)) |-> run_cnt == '0); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && $stable(win_len)) |-> (run_cnt == '0 || run_cnt < win_len)); // R5

endmodule

bind csync_qual_filter csync_qual_filter_chk #(
  .LEN_W (LEN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .filt_en  (filt_en),
  .win_len  (win_len),
  .sync_out (sync_out),
  .smp_lvl  (smp_lvl),
  .qual_lvl (qual_lvl),
  .run_cnt  (run_cnt)
);

// File: tb/csync_qual_filter_tb.sv
module csync_qual_filter_tb;

  localparam int LEN_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync_in = 1'b1;
  logic             filt_en = 1'b0;
  logic [LEN_W-1:0] win_len = '0;
  logic             sync_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  csync_qual_filter #(.LEN_W(LEN_W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_in),
    .filt_en  (filt_en),
    .win_len  (win_len),
    .sync_out (sync_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One isolated pulse of the opposite level, width w samples, on a settled base.
  // Index m counts falling edges after the pulse starts; an input change set up
  // before edge k is visible at m = 3 in bypass and m = 3 + L when filtering.
  task automatic run_pulse(input bit base, input int w, input bit en, input int len,
                           input string req);
    int L;
    int cnt;
    int first;
    L = (len == 0) ? 1 : len;
    filt_en = en;
    win_len = LEN_W'(len);
    sync_in = base;
    repeat (40) @(negedge clk);
    check(req, "settled level", int'(sync_out), int'(base));
    sync_in = ~base;
    cnt = 0;
    first = -1;
    for (int m = 1; m <= 60; m++) begin
      @(negedge clk);
      if (sync_out != base) begin
        cnt++;
        if (first < 0) first = m;
      end
      if (m == w) sync_in = base;
    end
    if (!en || w >= L) begin
      check(req, $sformatf("width base=%0d w=%0d en=%0d L=%0d", base, w, en, L), cnt, w);
      check(req, $sformatf("edge time base=%0d w=%0d en=%0d L=%0d", base, w, en, L),
            first, en ? 3 + L : 3);
    end else begin
      check(req, $sformatf("removed base=%0d w=%0d L=%0d", base, w, L), cnt, 0);
    end
  endtask

  // Two short runs split by one sample of the old level
  task automatic run_split(input int len);
    int cnt;
    filt_en = 1'b1;
    win_len = LEN_W'(len);
    sync_in = 1'b1;
    repeat (40) @(negedge clk);
    cnt = 0;
    for (int m = 0; m < 60; m++) begin
      if (m < len - 1) sync_in = 1'b0;
      else if (m == len - 1) sync_in = 1'b1;
      else if (m < 2 * len - 1) sync_in = 1'b0;
      else sync_in = 1'b1;
      @(negedge clk);
      if (sync_out == 1'b0) cnt++;
    end
    check("R7", $sformatf("split runs L=%0d", len), cnt, 0);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    int lens[5] = '{0, 1, 2, 3, 6};
    // R1: reset holds the idle level even with the input active
    sync_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "output during reset", int'(sync_out), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "first cycle after reset", int'(sync_out), 1);
    sync_in = 1'b1;

    // R2: bypass passes every width with fixed latency
    for (int w = 1; w <= 4; w++) begin
      run_pulse(1'b1, w, 1'b0, 5, "R2");
      run_pulse(1'b0, w, 1'b0, 5, "R2");
    end

    // R3/R4/R5/R6/R8: sweep windows and widths around the threshold
    foreach (lens[i]) begin
      for (int w = 1; w <= lens[i] + 2; w++) begin
        run_pulse(1'b1, w, 1'b1, lens[i],
                  (lens[i] <= 1) ? "R6" : ((w < lens[i]) ? "R5" : "R4"));
        run_pulse(1'b0, w, 1'b1, lens[i],
                  (lens[i] <= 1) ? "R6" : ((w < lens[i]) ? "R5" : "R3"));
      end
    end

    // R8: same pulse in each mode differs only in delay
    run_pulse(1'b1, 2, 1'b0, 4, "R8");
    run_pulse(1'b1, 2, 1'b1, 4, "R8");

    run_split(3);
    run_split(6);

    done = 1'b1;
    report();
  end

endmodule